// File: doc/BRIEF.md
# Residue Estimate Corrector

This block refines the code of a successive-approximation converter whose final comparison has been repeated N times. Alongside each raw code it receives k, the number of those N decisions that came out as 1. Each value of k stands for one precomputed estimate of the residue that was left over at the comparator input. The block looks up that estimate in one of several tables and subtracts it from the code. The result is a corrected sample with fractional bits below one LSB.

Each table belongs to one comparator-noise level; the default build holds three of them. A select input that travels with each sample chooses which table applies. Every entry can be rewritten through a write port, so tables worked out offline can be loaded at run time. After reset every table holds a linear ramp from -1 LSB to +1 LSB, spread evenly over k. Apart from the lookup and one subtraction, no arithmetic is done for each sample. The result is registered, with one cycle of latency.

Top module: `resid_corrector`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_data` is 0 until the first accepted sample.
- R2: After reset, entry k of every table holds round(16*(2k-N)/N) in signed units of 1/16 LSB, with ties rounded away from zero (N = 17 by default).
- R3: A sample accepted with `in_valid` = 1 at a clock edge appears on the next edge: `out_valid` = 1 and `out_data` = 16*code - est[sel][k], in two's complement with 4 fractional bits. `out_valid` is 0 after any edge at which `in_valid` was 0.
- R4: While `in_valid` is 0, `out_data` holds its last value, whatever the code, count and select inputs do.
- R5: A write with `wr_en` = 1 stores `wr_val` in entry `wr_idx` of table `wr_sel` at the clock edge. A sample taken at that same edge still uses the old entry; samples on later edges use the new one.
- R6: A write is ignored when `wr_idx` > N or when `wr_sel` is not a valid table number (>= 3 by default).
- R7: A count `in_count` greater than N is treated as N.
- R8: A select value that is not a valid table number (3 by default) uses table 0.
- R9: A write changes only the one addressed entry. The other entries and the other tables are left as they were.
- R10: `out_data` is wide enough for the full range. Code 2047 with estimate -128 gives +32880, and code 0 with estimate +127 gives -127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this cycle |
| in_code | input | 11 | Raw converter code |
| in_count | input | 5 | Number of 1 decisions among the N repeats |
| in_sel | input | 2 | Table select for this sample |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table number to write |
| wr_idx | input | 5 | Entry (k value) to write |
| wr_val | input | 8 | Signed estimate, 4 fractional bits |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | 17 | Signed corrected sample, 4 fractional bits |

## Verification
A table update and a lookup of the same entry can fall on the same clock edge. The bench provokes this by raising `wr_en` and `in_valid` in the same cycle, aimed at one entry, using a value that differs from the stored one. The output of that sample must reflect the old entry. The next sample of the same entry must reflect the new one, which shows both that the lookup came first and that the write was not lost.

// File: rtl/resid_pkg.sv
package resid_pkg;

  // Linear ramp estimate in units of 2^-frac LSB: (2k-n)/n, rounded half away from zero.
  function automatic int avg_est(input int n, input int k, input int frac);
    int num;
    num = (2 * k - n) * (1 << frac);
    if (num >= 0) return (num + n / 2) / n;
    return -((-num + n / 2) / n);
  endfunction

  function automatic int width_for(input int count);
    return (count <= 1) ? 1 : $clog2(count);
  endfunction

endpackage

// File: rtl/rse_est_table.sv
module rse_est_table #(
  parameter int N     = 17,
  parameter int NTAB  = 3,
  parameter int EST_W = 8,
  parameter int FRAC  = 4,
  parameter int CNT_W = 5,
  parameter int SEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [CNT_W-1:0]        wr_idx,
  input  logic signed [EST_W-1:0] wr_val,
  input  logic [CNT_W-1:0]        rd_idx,
  input  logic [SEL_W-1:0]        rd_sel,
  output logic signed [EST_W-1:0] rd_est,
  output logic                    wr_commit
);
  import resid_pkg::*;

  localparam logic [CNT_W-1:0] K_MAX    = CNT_W'(N);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NTAB - 1);

  logic signed [EST_W-1:0] tab_out [0:NTAB-1];

  assign wr_commit = wr_en && (wr_idx <= K_MAX) && (wr_sel <= SEL_LAST);

  genvar t;
  generate
    for (t = 0; t < NTAB; t++) begin : g_tab
      logic signed [EST_W-1:0] ent [0:N];
      logic                    hit;

      assign hit = wr_commit && (wr_sel == SEL_W'(t));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int j = 0; j <= N; j++) ent[j] <= EST_W'(avg_est(N, j, FRAC));
        end else if (hit) begin
          ent[wr_idx] <= wr_val;
        end
      end

      assign tab_out[t] = ent[rd_idx];
    end
  endgenerate

  assign rd_est = tab_out[rd_sel];

endmodule

// File: rtl/rse_subtract.sv
module rse_subtract #(
  parameter int CODE_W = 11,
  parameter int FRAC   = 4,
  parameter int EST_W  = 8,
  parameter int OUT_W  = 17
) (
  input  logic [CODE_W-1:0]       code,
  input  logic signed [EST_W-1:0] est,
  output logic signed [OUT_W-1:0] diff
);
  logic signed [OUT_W-1:0] code_fx;
  logic signed [OUT_W-1:0] est_x;

  always_comb begin
    code_fx = $signed(OUT_W'({code, {FRAC{1'b0}}}));
    est_x   = OUT_W'(est);
    diff    = code_fx - est_x;
  end

endmodule

// File: rtl/resid_corrector.sv
module resid_corrector #(
  parameter int N      = 17,
  parameter int NTAB   = 3,
  parameter int CODE_W = 11,
  parameter int FRAC   = 4,
  parameter int EST_W  = 8,
  parameter int CNT_W  = resid_pkg::width_for(N + 1),
  parameter int SEL_W  = resid_pkg::width_for(NTAB),
  parameter int OUT_W  = CODE_W + FRAC + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [CNT_W-1:0]        in_count,
  input  logic [SEL_W-1:0]        in_sel,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [CNT_W-1:0]        wr_idx,
  input  logic signed [EST_W-1:0] wr_val,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam logic [CNT_W-1:0] K_MAX    = CNT_W'(N);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NTAB - 1);

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0]        k_eff;
  logic [SEL_W-1:0]        sel_pick;
  logic signed [EST_W-1:0] est_pick;
  logic signed [OUT_W-1:0] corr_next;
  logic                    wr_commit;

  assign k_eff    = (in_count > K_MAX) ? K_MAX : in_count;
  assign sel_pick = (in_sel > SEL_LAST) ? '0 : in_sel;

  rse_est_table #(
    .N(N), .NTAB(NTAB), .EST_W(EST_W), .FRAC(FRAC), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val),
    .rd_idx   (k_eff),
    .rd_sel   (sel_pick),
    .rd_est   (est_pick),
    .wr_commit(wr_commit)
  );

  rse_subtract #(
    .CODE_W(CODE_W), .FRAC(FRAC), .EST_W(EST_W), .OUT_W(OUT_W)
  ) u_sub (
    .code(in_code),
    .est (est_pick),
    .diff(corr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= corr_next;
    end
  end

endmodule

// File: rtl/resid_corrector_chk.sv
module resid_corrector_chk #(
  parameter int N      = 17,
  parameter int NTAB   = 3,
  parameter int CODE_W = 11,
  parameter int FRAC   = 4,
  parameter int EST_W  = 8,
  parameter int CNT_W  = 5,
  parameter int SEL_W  = 2,
  parameter int OUT_W  = 17
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [CODE_W-1:0]       in_code,
  input logic [CNT_W-1:0]        in_count,
  input logic [SEL_W-1:0]        in_sel,
  input logic [SEL_W-1:0]        wr_sel,
  input logic [CNT_W-1:0]        wr_idx,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data,
  input logic [CNT_W-1:0]        k_eff,
  input logic [SEL_W-1:0]        sel_pick,
  input logic signed [EST_W-1:0] est_pick,
  input logic                    wr_commit
);
  localparam logic [CNT_W-1:0] K_MAX    = CNT_W'(N);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NTAB - 1);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R3

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R3

  AST_CORR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data == (OUT_W'({$past(in_code), {FRAC{1'b0}}}) - OUT_W'($past(est_pick)))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R4

  AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (wr_idx <= K_MAX) && (wr_sel <= SEL_LAST)); // R6

  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_count > K_MAX)) |-> (k_eff == K_MAX)); // R7

  AST_SEL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_sel > SEL_LAST)) |-> (sel_pick == '0)); // R8

endmodule

bind resid_corrector resid_corrector_chk #(
  .N(N), .NTAB(NTAB), .CODE_W(CODE_W), .FRAC(FRAC), .EST_W(EST_W),
  .CNT_W(CNT_W), .SEL_W(SEL_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
  .in_count(in_count), .in_sel(in_sel), .wr_sel(wr_sel), .wr_idx(wr_idx),
  .out_valid(out_valid), .out_data(out_data), .k_eff(k_eff),
  .sel_pick(sel_pick), .est_pick(est_pick), .wr_commit(wr_commit)
);

// File: tb/resid_corrector_test.sv
module resid_corrector_test;
  localparam int N = 17;
  localparam int NT = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [10:0]       in_code = '0;
  logic [4:0]        in_count = '0;
  logic [1:0]        in_sel = '0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = '0;
  logic [4:0]        wr_idx = '0;
  logic signed [7:0] wr_val = '0;
  logic              out_valid;
  logic signed [16:0] out_data;

  int total = 0;
  int bad = 0;
  int model [NT][N+1];

  always #2 clk = ~clk;

  resid_corrector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .in_count(in_count), .in_sel(in_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_val(wr_val), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_out(input int code, input int k, input int sel);
    int ke, se;
    ke = (k > N) ? N : k;
    se = (sel >= NT) ? 0 : sel;
    return code * 16 - model[se][ke];
  endfunction

  task automatic model_write(input int sel, input int idx, input int val);
    if (sel < NT && idx <= N) model[sel][idx] = val;
  endtask

  task automatic do_write(input int sel, input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_idx = 5'(idx); wr_val = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(sel, idx, val);
  endtask

  task automatic do_sample(input string req, input int code, input int k, input int sel);
    @(negedge clk);
    in_valid = 1'b1; in_code = 11'(code); in_count = 5'(k); in_sel = 2'(sel);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, int'(out_valid), 1);
    chk(req, int'(out_data), expect_out(code, k, sel));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 data after reset", int'(out_data), 0);
  endtask

  task automatic t_defaults;
    for (int s = 0; s < NT; s++)
      for (int k = 0; k <= N; k++)
        do_sample("R2 default table", 1000 + 37 * k, k, s);
  endtask

  task automatic t_stream;
    // back-to-back samples, select changes every cycle
    int codes [6] = '{5, 2047, 0, 1234, 777, 64};
    int ks [6] = '{0, 17, 9, 3, 12, 8};
    int ss [6] = '{2, 0, 1, 2, 1, 0};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R3 stream valid", int'(out_valid), 1);
        chk("R3 stream data", int'(out_data), expect_out(codes[i-1], ks[i-1], ss[i-1]));
      end
      in_valid = 1'b1; in_code = 11'(codes[i]); in_count = 5'(ks[i]); in_sel = 2'(ss[i]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 stream last", int'(out_data), expect_out(codes[5], ks[5], ss[5]));
    @(negedge clk);
    chk("R3 valid drops", int'(out_valid), 0);
  endtask

  task automatic t_hold;
    int last;
    do_sample("R4 setup", 321, 4, 1);
    last = int'(out_data);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_code = 11'(100 * i + 7); in_count = 5'(i); in_sel = 2'(i);
      @(negedge clk);
      chk("R4 idle valid", int'(out_valid), 0);
      chk("R4 idle hold", int'(out_data), last);
    end
  endtask

  task automatic t_write;
    do_write(1, 0, -16);
    do_write(1, 8, -3);
    do_write(1, 17, 16);
    do_sample("R5 new entry k0", 50, 0, 1);
    do_sample("R5 new entry k8", 50, 8, 1);
    do_sample("R5 new entry k17", 50, 17, 1);
    do_sample("R9 same table other entry", 50, 9, 1);
    for (int k = 0; k <= N; k++) begin
      do_sample("R9 table0 untouched", 900, k, 0);
      do_sample("R9 table2 untouched", 900, k, 2);
    end
  endtask

  task automatic t_collide;
    int old_est;
    old_est = model[2][5];
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_idx = 5'd5; wr_val = 8'sd50;
    in_valid = 1'b1; in_code = 11'd400; in_count = 5'd5; in_sel = 2'd2;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    chk("R5 same-edge uses old", int'(out_data), 400 * 16 - old_est);
    model_write(2, 5, 50);
    do_sample("R5 next sample uses new", 400, 5, 2);
  endtask

  task automatic t_bad_write;
    do_write(0, 18, 99);
    do_write(0, 31, 99);
    do_write(3, 4, 99);
    for (int s = 0; s < NT; s++)
      for (int k = 0; k <= N; k++)
        do_sample("R6 ignored write", 1500, k, s);
  endtask

  task automatic t_clamp;
    do_write(0, 17, 11);
    do_sample("R7 count 18", 222, 18, 0);
    do_sample("R7 count 31", 222, 31, 0);
    chk("R7 clamp value", int'(out_data), 222 * 16 - 11);
  endtask

  task automatic t_fallback;
    do_write(0, 6, 77);
    do_sample("R8 sel 3 uses table 0", 600, 6, 3);
    chk("R8 value", int'(out_data), 600 * 16 - 77);
  endtask

  task automatic t_extremes;
    do_write(2, 0, -128);
    do_write(2, 1, 127);
    do_sample("R10 top of range", 2047, 0, 2);
    chk("R10 max value", int'(out_data), 32880);
    do_sample("R10 bottom of range", 0, 1, 2);
    chk("R10 min value", int'(out_data), -127);
  endtask

  initial begin
    for (int s = 0; s < NT; s++)
      for (int k = 0; k <= N; k++)
        model[s][k] = int'(16.0 * real'(2 * k - N) / real'(N));
    t_reset();
    t_defaults();
    t_stream();
    t_hold();
    t_write();
    t_collide();
    t_bad_write();
    t_clamp();
    t_fallback();
    t_extremes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule